// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration bitstream into a programmable device through its serial slave port. Five pins connect to the device: an active-low program strobe, a configuration clock, a serial data line, and two status inputs (init and done). On a start request the sequencer pulls program low and waits for init to fall. It then releases program and waits for init to rise again. Next it clocks every payload byte out, most significant bit first. Last, it waits for done to go high.

Payload bytes arrive on a valid/ready stream whose final byte carries an end marker. Each of the three waiting phases has its own timeout, counted on an external 1 ms tick, and its own result code. The block reports the result through a registered 2-bit status, a one-cycle finish pulse and a busy flag. Init and done are asynchronous to the system clock, so each passes through a synchroniser before the block uses it.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, and whenever not busy, prog_n_o, cclk_o and dout_o are all 1, busy_o is 0 and s_ready_o is 0. The reset value of status_o is 0.
- R2: A start_i pulse while idle raises busy_o and drives prog_n_o low with cclk_o and dout_o held at 1. prog_n_o stays low until the synchronised init_i reads 0. Exactly one low period of prog_n_o occurs per sequence.
- R3: Once init_i has fallen, prog_n_o returns to 1. No configuration clock edge is produced until the synchronised init_i reads 1 again.
- R4: Each of the three waiting phases times out once POLL_LIMIT (default 4) tick_ms_i pulses have arrived while its condition is unmet. With init_i stuck high, exactly 4 ticks fall inside the busy window.
- R5: status_o is written when finish_o rises and holds its value at all other times. The encoding is: 0 = success, 1 = init never fell, 2 = init never rose again, 3 = done never rose.
- R6: Every accepted byte is shifted out on dout_o, most significant bit first, 8 bits per byte, in the order the bytes were accepted. This also holds when done later fails.
- R7: For each bit, cclk_o is low for exactly CLK_HALF cycles with the new data bit on dout_o, then high for CLK_HALF cycles with dout_o unchanged. prog_n_o is 1 whenever cclk_o is 0.
- R8: s_ready_o is 1 only in the data phase, when no bit of the previous byte is still going out and the end-marked byte has not yet been taken. A byte is accepted when s_valid_i and s_ready_o are both 1 at a clock edge. After the end-marked byte has been shifted out, the block waits for done.
- R9: finish_o is a single-cycle pulse at the end of every sequence. busy_o falls on the cycle after it.
- R10: start_i is ignored while busy_o is 1. It neither restarts the sequence nor produces a second program pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration sequence (one cycle) |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond, paces timeouts |
| s_valid_i | input | 1 | Payload byte valid |
| s_data_i | input | DATA_W | Payload byte |
| s_last_i | input | 1 | Marks the final payload byte |
| s_ready_o | output | 1 | Block can accept a payload byte |
| prog_n_o | output | 1 | Active-low program strobe to the device |
| cclk_o | output | 1 | Configuration clock to the device |
| dout_o | output | 1 | Serial configuration data to the device |
| init_i | input | 1 | Device init status (asynchronous) |
| done_i | input | 1 | Device done status (asynchronous) |
| busy_o | output | 1 | A sequence is in progress |
| finish_o | output | 1 | One-cycle pulse when a sequence ends |
| status_o | output | 2 | Result of the last sequence |

## Verification
A wrong phase state shows first on prog_n_o: either a second low period appears, or prog_n_o stays low past the first init edge seen after synchronisation, which is about three cycles. A corrupt bit counter or shift register shows on the first affected rising edge of cclk_o: as a wrong bit value, a bit-count mismatch against the accepted bytes, or a low phase whose length is not CLK_HALF. A timer or result-code fault stays hidden until the sequence ends. At that point it appears as a wrong status_o value, or as a finish arriving after the wrong number of ticks.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PROG,
      ST_INIT_HI,
      ST_SHIFT,
      ST_DONE_W,
      ST_FIN
   } ld_state_e;

   typedef enum logic [1:0] {
      RES_OK           = 2'd0,
      RES_NO_INIT_LOW  = 2'd1,
      RES_NO_INIT_HIGH = 2'd2,
      RES_NO_DONE      = 2'd3
   } ld_result_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("cfg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL}};
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];

endmodule

// File: rtl/cfg_tick_timer.sv
module cfg_tick_timer #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic expired
);

   localparam int            CW  = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (clear)              cnt <= '0;
      else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == LIM);

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter #(
   parameter int DW   = 8,
   parameter int HALF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          park,
   input  logic          load,
   input  logic [DW-1:0] din,
   output logic          empty,
   output logic          byte_done,
   output logic          cclk,
   output logic          dout
);

   localparam int            HW    = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [HW-1:0] HLAST = HW'(HALF - 1);
   localparam int            BW    = $clog2(DW + 1);
   localparam logic [BW-1:0] BFULL = BW'(DW);
   localparam logic [BW-1:0] BONE  = BW'(1);

   logic [DW-1:0] sh;
   logic [BW-1:0] bits;
   logic [HW-1:0] hcnt;
   logic          phase_hi;
   logic          active;
   logic          cclk_q;
   logic          dout_q;
   logic          half_end;

   assign half_end  = (hcnt == HLAST);
   assign byte_done = active && phase_hi && half_end && (bits == BONE);
   assign empty     = !active;
   assign cclk      = cclk_q;
   assign dout      = dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         bits     <= '0;
         hcnt     <= '0;
         phase_hi <= 1'b0;
         active   <= 1'b0;
         cclk_q   <= 1'b1;
         dout_q   <= 1'b1;
      end else if (park) begin
         active   <= 1'b0;
         phase_hi <= 1'b0;
         hcnt     <= '0;
         cclk_q   <= 1'b1;
         dout_q   <= 1'b1;
      end else if (load && !active) begin
         sh       <= din;
         bits     <= BFULL;
         hcnt     <= '0;
         phase_hi <= 1'b0;
         active   <= 1'b1;
         cclk_q   <= 1'b0;
         dout_q   <= din[DW-1];
      end else if (active) begin
         if (!half_end) begin
            hcnt <= hcnt + 1'b1;
         end else begin
            hcnt <= '0;
            if (!phase_hi) begin
               phase_hi <= 1'b1;
               cclk_q   <= 1'b1;
            end else begin
               phase_hi <= 1'b0;
               sh       <= {sh[DW-2:0], 1'b0};
               bits     <= bits - 1'b1;
               if (bits == BONE) begin
                  active <= 1'b0;
               end else begin
                  cclk_q <= 1'b0;
                  dout_q <= sh[DW-2];
               end
            end
         end
      end
   end

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_loader_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_HALF    = 2,
   parameter int POLL_LIMIT  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              tick_ms_i,
   input  logic              s_valid_i,
   input  logic [DATA_W-1:0] s_data_i,
   input  logic              s_last_i,
   output logic              s_ready_o,
   output logic              prog_n_o,
   output logic              cclk_o,
   output logic              dout_o,
   input  logic              init_i,
   input  logic              done_i,
   output logic              busy_o,
   output logic              finish_o,
   output logic [1:0]        status_o
);

   if (DATA_W < 2) begin : g_bad_width
      $error("cfg_serial_loader: DATA_W must be at least 2");
   end
   if (CLK_HALF < 1) begin : g_bad_half
      $error("cfg_serial_loader: CLK_HALF must be at least 1");
   end
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("cfg_serial_loader: POLL_LIMIT must be at least 1");
   end

   ld_state_e  state_q, state_d;
   ld_result_e status_q, code_d;
   logic       prog_n_q;
   logic       last_q;
   logic       init_s, done_s;
   logic       expired;
   logic       sh_empty, sh_byte_done;
   logic       load;

   cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_init (
      .clk(clk), .rst_n(rst_n), .d(init_i), .q(init_s)
   );

   cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_done (
      .clk(clk), .rst_n(rst_n), .d(done_i), .q(done_s)
   );

   cfg_tick_timer #(.LIMIT(POLL_LIMIT)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .clear(state_d != state_q),
      .tick(tick_ms_i),
      .expired(expired)
   );

   assign s_ready_o = (state_q == ST_SHIFT) && sh_empty && !last_q;
   assign load      = s_valid_i && s_ready_o;

   cfg_bit_shifter #(.DW(DATA_W), .HALF(CLK_HALF)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .park(state_d == ST_IDLE),
      .load(load),
      .din(s_data_i),
      .empty(sh_empty),
      .byte_done(sh_byte_done),
      .cclk(cclk_o),
      .dout(dout_o)
   );

   always_comb begin
      state_d = state_q;
      code_d  = status_q;
      case (state_q)
         ST_IDLE:    if (start_i) state_d = ST_PROG;
         ST_PROG: begin
            if (!init_s) state_d = ST_INIT_HI;
            else if (expired) begin
               state_d = ST_FIN;
               code_d  = RES_NO_INIT_LOW;
            end
         end
         ST_INIT_HI: begin
            if (init_s) state_d = ST_SHIFT;
            else if (expired) begin
               state_d = ST_FIN;
               code_d  = RES_NO_INIT_HIGH;
            end
         end
         ST_SHIFT:   if (sh_byte_done && last_q) state_d = ST_DONE_W;
         ST_DONE_W: begin
            if (done_s) begin
               state_d = ST_FIN;
               code_d  = RES_OK;
            end else if (expired) begin
               state_d = ST_FIN;
               code_d  = RES_NO_DONE;
            end
         end
         ST_FIN:     state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         status_q <= RES_OK;
         prog_n_q <= 1'b1;
         last_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         prog_n_q <= (state_d != ST_PROG);
         if (state_d == ST_FIN && state_q != ST_FIN) status_q <= code_d;
         if (state_q == ST_IDLE)       last_q <= 1'b0;
         else if (load && s_last_i)    last_q <= 1'b1;
      end
   end

   assign prog_n_o = prog_n_q;
   assign busy_o   = (state_q != ST_IDLE);
   assign finish_o = (state_q == ST_FIN);
   assign status_o = status_q;

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       s_ready_o,
   input logic       prog_n_o,
   input logic       cclk_o,
   input logic       dout_o,
   input logic       busy_o,
   input logic       finish_o,
   input logic [1:0] status_o
);

   p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (prog_n_o && cclk_o && dout_o && !s_ready_o));

   p_prog_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_n_o |-> (cclk_o && !s_ready_o));

   p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !finish_o |-> $stable(status_o));

   p_clk_low_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cclk_o |-> prog_n_o);

   p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && cclk_o && $past(cclk_o)) |-> $stable(dout_o));

   p_ready_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready_o |-> (busy_o && prog_n_o && cclk_o));

   p_finish_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      finish_o |=> !finish_o);

   p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(finish_o));

endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
   .clk(clk),
   .rst_n(rst_n),
   .s_ready_o(s_ready_o),
   .prog_n_o(prog_n_o),
   .cclk_o(cclk_o),
   .dout_o(dout_o),
   .busy_o(busy_o),
   .finish_o(finish_o),
   .status_o(status_o)
);

// File: tb/cfg_serial_loader_bench.sv
module cfg_serial_loader_bench;

   localparam int HALF = 2;
   localparam int LIM  = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       tick = 1'b0;
   logic       s_valid = 1'b0;
   logic [7:0] s_data = 8'h00;
   logic       s_last = 1'b0;
   logic       s_ready_o, prog_n_o, cclk_o, dout_o, busy_o, finish_o;
   logic [1:0] status_o;
   logic       init_i = 1'b1;
   logic       done_i = 1'b0;

   int total = 0;
   int bad   = 0;

   // device model and monitor state
   logic model_rst = 1'b0;
   logic en_low = 1'b1, en_high = 1'b1, en_done = 1'b1;
   int   exp_bits = 0;
   logic cap [0:1023];
   int   n_rise = 0, low_run = 0, low_err = 0, hold_err = 0, prog_err = 0;
   int   prog_falls = 0, ticks_busy = 0, fin_seen = 0, ready_seen = 0;
   int   fin_status = 0;
   logic prev_cclk = 1'b1, prev_dout = 1'b1, prev_busy = 1'b0, prev_prog = 1'b1;
   logic [7:0] bytes_q [0:63];

   always #5 clk = ~clk;

   cfg_serial_loader #(.DATA_W(8), .CLK_HALF(HALF), .POLL_LIMIT(LIM), .SYNC_STAGES(2))
   u_cfg_serial_loader (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_ms_i(tick),
      .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready_o),
      .prog_n_o(prog_n_o), .cclk_o(cclk_o), .dout_o(dout_o),
      .init_i(init_i), .done_i(done_i),
      .busy_o(busy_o), .finish_o(finish_o), .status_o(status_o)
   );

   initial begin
      forever begin
         repeat (39) @(posedge clk);
         tick <= 1'b1;
         @(posedge clk);
         tick <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (model_rst) begin
         n_rise = 0; low_run = 0; low_err = 0; hold_err = 0; prog_err = 0;
         prog_falls = 0; ticks_busy = 0; fin_seen = 0; ready_seen = 0;
         init_i <= 1'b1;
         done_i <= 1'b0;
      end else begin
         if (cclk_o && !prev_cclk) begin
            if (n_rise < 1024) cap[n_rise] = dout_o;
            n_rise++;
            if (low_run != HALF) low_err++;
         end
         low_run = cclk_o ? 0 : low_run + 1;
         if (busy_o && prev_busy && cclk_o && prev_cclk && dout_o != prev_dout) hold_err++;
         if (!cclk_o && !prog_n_o) prog_err++;
         if (!prog_n_o && prev_prog) prog_falls++;
         if (tick && busy_o) ticks_busy++;
         if (s_ready_o) ready_seen++;
         if (finish_o) begin fin_seen++; fin_status = status_o; end
         if (!prog_n_o && en_low) init_i <= 1'b0;
         else if (prog_n_o && en_high && !init_i) init_i <= 1'b1;
         done_i <= en_done && exp_bits > 0 && n_rise >= exp_bits;
      end
      prev_cclk = cclk_o; prev_dout = dout_o; prev_busy = busy_o; prev_prog = prog_n_o;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_status(input int mode);
      return mode; // 0 ok, 1 init stuck high, 2 init stuck low, 3 no done
   endfunction

   function automatic logic exp_bit(input int k);
      return bytes_q[k / 8][7 - (k % 8)];
   endfunction

   task automatic feed(input int n, input bit rnd_gap);
      for (int i = 0; i < n; i++) begin
         int wd;
         @(posedge clk);
         s_valid <= 1'b1; s_data <= bytes_q[i]; s_last <= (i == n - 1);
         wd = 0;
         do begin @(negedge clk); wd++; end while (!s_ready_o && wd < 5000);
         @(posedge clk);
         s_valid <= 1'b0; s_last <= 1'b0;
         if (rnd_gap) repeat ($urandom_range(0, 3)) @(posedge clk);
      end
   endtask

   // mode: 0 success, 1 init never low, 2 init never high, 3 done never high
   task automatic run(input int mode, input int n, input bit poke);
      int wd;
      int mism;
      @(posedge clk);
      model_rst <= 1'b1;
      en_low <= (mode != 1); en_high <= (mode != 2); en_done <= (mode != 3);
      exp_bits <= (mode == 0 || mode == 3) ? n * 8 : 0;
      @(posedge clk);
      model_rst <= 1'b0;
      @(posedge clk);
      start_i <= 1'b1;
      @(posedge clk);
      start_i <= 1'b0;
      if (mode == 0 || mode == 3) begin
         feed(n, 1'b1);
         if (poke) begin
            @(posedge clk); start_i <= 1'b1;
            @(posedge clk); start_i <= 1'b0;
         end
      end
      wd = 0;
      while (fin_seen == 0 && wd < 20000) begin @(negedge clk); wd++; end
      repeat (10) @(negedge clk);
      chk(fin_status == exp_status(mode), "R5 status code", fin_status, exp_status(mode));
      chk(fin_seen == 1, "R9 single finish pulse", fin_seen, 1);
      chk(prog_falls == 1, "R2/R10 one program pulse", prog_falls, 1);
      chk(!busy_o && prog_n_o && cclk_o && dout_o, "R1 idle lines after end",
          {busy_o, prog_n_o, cclk_o, dout_o}, 4'b0111);
      if (mode == 0 || mode == 3) begin
         mism = 0;
         for (int k = 0; k < n * 8; k++) if (cap[k] !== exp_bit(k)) mism++;
         chk(n_rise == n * 8, "R6 bit count", n_rise, n * 8);
         chk(mism == 0, "R6 MSB-first data", mism, 0);
         chk(low_err == 0 && hold_err == 0 && prog_err == 0, "R7 bit timing",
             low_err + hold_err + prog_err, 0);
      end else begin
         chk(n_rise == 0, mode == 1 ? "R2 no clock before init low" : "R3 no clock before init high",
             n_rise, 0);
         chk(ready_seen == 0, "R8 no ready outside data phase", ready_seen, 0);
         if (mode == 1) chk(ticks_busy == LIM, "R4 timeout tick count", ticks_busy, LIM);
         else           chk(ticks_busy >= LIM, "R4 timeout tick count", ticks_busy, LIM);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n <= 1'b1;
      @(negedge clk);
      chk(prog_n_o && cclk_o && dout_o && !busy_o && !s_ready_o && status_o == 2'd0,
          "R1 reset state", {prog_n_o, cclk_o, dout_o, busy_o, s_ready_o}, 5'b11100);
      void'($urandom(32'h5eed1234));
      bytes_q[0] = 8'hC3;
      run(0, 1, 1'b0);
      bytes_q[0] = 8'h00; bytes_q[1] = 8'hFF; bytes_q[2] = 8'hA5;
      run(0, 3, 1'b0);
      run(1, 1, 1'b0);
      run(2, 1, 1'b0);
      bytes_q[0] = 8'h81; bytes_q[1] = 8'h7E;
      run(3, 2, 1'b0);
      for (int i = 0; i < 4; i++) bytes_q[i] = 8'($urandom);
      run(0, 4, 1'b1); // R10: start pulsed mid-sequence
      for (int r = 0; r < 8; r++) begin
         int n = $urandom_range(1, 12);
         for (int i = 0; i < n; i++) bytes_q[i] = 8'($urandom);
         run(($urandom_range(0, 3) == 0) ? 3 : 0, n, r[0]);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule